// File: doc/BRIEF.md
# Nested Hardware Loop Sequencer

This unit sits beside the fetch stage of a simple 32-bit core and runs counted loops without any per-pass branch instructions. When the core decodes a loop-start instruction, it presents a pass count, the address of the loop's last instruction and the address of the loop's first instruction. The unit then spends three busy cycles saving the enclosing loop's context on a private 15-entry frame stack, loading the new count and end address, and finally raising the loop-active flag.

While the flag is up, every fetch whose address equals the end address is treated as the last instruction of a pass. If passes remain, the unit decrements the count and drives a fetch redirect to the loop-top address, which it reads from the newest stack frame without popping it. On the last pass it lets fetch fall through. It then spends one cycle popping the saved address/status frame, which restores the previous flag, and one cycle popping the saved end-address/count frame, which restores the outer loop. Loops nest until the stack is full. Overflow and underflow raise sticky error flags.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset the flag, count, end address and depth read zero. Busy, redirect and both error flags are low.
- R2: A start command seen while busy is low is accepted, and busy is then high for exactly three cycles. A start seen while busy is high, or in the same cycle as a last-pass match, is ignored.
- R3: The first setup cycle pushes the frame {end address, count} and loads the count. With `cnt_short_i` high the count is the 19-bit `cnt_imm_i` zero-extended to 32 bits, and `cnt_reg_i` is ignored. Otherwise the count is `cnt_reg_i`.
- R4: The second setup cycle pushes the frame {loop top, status}, where bit 0 of the stored status is replaced by the current flag, and loads the end address. A completed setup raises the depth by two.
- R5: The flag reads one from the cycle after the third setup cycle.
- R6: When the flag is set, the unit is not busy, a fetch is valid and the fetch address equals the end address with a count other than one, the redirect is high in that same cycle with the loop-top address of the newest loop. The count drops by one at the next edge and the depth is unchanged. A fetch at any other address gives no redirect.
- R7: A loaded count of zero is not a last pass: the first match redirects and the count becomes 0xFFFFFFFF, so the loop makes 2^32 passes.
- R8: A match with count one gives no redirect. The next cycle is busy, the flag holds bit 0 of the popped status and the depth has dropped by one. One cycle later busy is low, the end address and count equal their pre-setup values, and the depth has dropped by two in total.
- R9: When an inner loop ends, the outer loop's count, end address and set flag are restored, and the outer loop's next match redirects to the outer loop top.
- R10: A push at depth 15 is dropped, the depth stays 15, and the overflow flag sets and stays set until reset.
- R11: A pop at depth 0 leaves the depth at 0 and sets the underflow flag, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| loop_start_i | input | 1 | Loop-start command from decode |
| cnt_short_i | input | 1 | Count comes from the short immediate field |
| cnt_imm_i | input | 19 | Short immediate count |
| cnt_reg_i | input | 32 | Full-width count from a register or memory operand |
| end_addr_i | input | 32 | Address of the last instruction of the loop |
| loop_top_i | input | 32 | Address of the first instruction after the loop-start instruction |
| status_i | input | 32 | Core status word to be saved |
| fetch_vld_i | input | 1 | A fetch happens this cycle |
| fetch_pc_i | input | 32 | Address being fetched |
| busy_o | output | 1 | Setup or unwind in progress; the core stalls |
| pc_ovr_vld_o | output | 1 | Redirect the next fetch |
| pc_ovr_o | output | 32 | Redirect address (loop top) |
| lc_o | output | 32 | Current loop count |
| la_o | output | 32 | Current loop end address |
| lf_o | output | 1 | Loop-active flag |
| depth_o | output | 4 | Frames held on the stack |
| ovf_o | output | 1 | Sticky stack overflow |
| unf_o | output | 1 | Sticky stack underflow |

## Verification
A loop-start command and a loop-end match can arrive in the same idle cycle. The bench drives both on the same clock edge in two settings. When the match is not the last pass, both must act: the redirect appears, the new loop is set up, and the count saved for the outer loop is the decremented one, which shows when the inner loop unwinds. When the match is the last pass, the unwind must win: the depth falls by two and stays there, and no setup follows.

// File: rtl/hwloop_pkg.sv
`timescale 1ns/1ps
package hwloop_pkg;

  parameter int unsigned WORD_W = 32;
  parameter int unsigned IMM_W  = 19;
  parameter int unsigned LF_POS = 0;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t hi;
    word_t lo;
  } frame_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAVE_CNT,
    ST_SAVE_PC,
    ST_ARM,
    ST_UNWIND
  } seq_state_e;

  function automatic word_t widen_imm(input logic [IMM_W-1:0] imm);
    return {{(WORD_W-IMM_W){1'b0}}, imm};
  endfunction

  function automatic word_t lc_after_pass(input word_t lc);
    return lc - word_t'(1);
  endfunction

  function automatic logic is_final_pass(input word_t lc);
    return lc == word_t'(1);
  endfunction

  function automatic word_t pack_status(input word_t sr, input logic lf);
    word_t keep;
    keep = ~(word_t'(1) << LF_POS);
    return (sr & keep) | (word_t'(lf) << LF_POS);
  endfunction

endpackage

// File: rtl/hwloop_stack.sv
`timescale 1ns/1ps
module hwloop_stack
  import hwloop_pkg::*;
#(
  parameter int unsigned DEPTH = 15,
  localparam int unsigned PTR_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  frame_t           din_i,
  output frame_t           top_o,
  output logic [PTR_W-1:0] depth_o,
  output logic             ovf_o,
  output logic             unf_o
);

  frame_t           mem_q [DEPTH];
  logic [PTR_W-1:0] sp_q;
  logic             full, empty;
  logic             do_push, do_pop, push_blocked, pop_blocked;
  logic [PTR_W-1:0] top_ptr;

  assign full         = (sp_q == PTR_W'(DEPTH));
  assign empty        = (sp_q == '0);
  assign do_push      = push_i && !full;
  assign do_pop       = pop_i && !empty;
  assign push_blocked = push_i && full;
  assign pop_blocked  = pop_i && empty;
  assign top_ptr      = sp_q - PTR_W'(1);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      if (do_push)      sp_q <= sp_q + PTR_W'(1);
      else if (do_pop)  sp_q <= top_ptr;
      if (push_blocked) ovf_o <= 1'b1;
      if (pop_blocked)  unf_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[sp_q[IDX_W-1:0]] <= din_i;
  end

  assign top_o   = empty ? '0 : mem_q[top_ptr[IDX_W-1:0]];
  assign depth_o = sp_q;

  AST_ONE_STACK_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i)); // R4
  AST_DEPTH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_q <= PTR_W'(DEPTH)); // R10
  AST_FULL_PUSH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_blocked |=> (depth_o == PTR_W'(DEPTH)) && ovf_o); // R10
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R10
  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_blocked |=> (depth_o == '0) && unf_o); // R11
  AST_UNF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> unf_o); // R11

endmodule

// File: rtl/hwloop_match.sv
`timescale 1ns/1ps
module hwloop_match
  import hwloop_pkg::*;
(
  input  logic  enable_i,
  input  logic  lf_i,
  input  logic  fetch_vld_i,
  input  word_t fetch_pc_i,
  input  word_t la_i,
  input  word_t lc_i,
  output logic  hit_o,
  output logic  repeat_o,
  output logic  exit_o
);

  logic last_pass;

  assign last_pass = is_final_pass(lc_i);
  assign hit_o     = enable_i && lf_i && fetch_vld_i && (fetch_pc_i == la_i);
  assign repeat_o  = hit_o && !last_pass;
  assign exit_o    = hit_o && last_pass;

endmodule

// File: rtl/hwloop_seq.sv
`timescale 1ns/1ps
module hwloop_seq
  import hwloop_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cnt_short_i,
  input  logic [IMM_W-1:0] cnt_imm_i,
  input  word_t            cnt_reg_i,
  input  word_t            end_addr_i,
  input  word_t            loop_top_i,
  input  word_t            status_i,
  input  logic             repeat_i,
  input  logic             exit_i,
  input  frame_t           stk_top_i,
  output logic             push_o,
  output logic             pop_o,
  output frame_t           push_data_o,
  output word_t            la_o,
  output word_t            lc_o,
  output logic             lf_o,
  output logic             busy_o
);

  seq_state_e state_q, state_d;
  word_t      cmd_cnt_q, cmd_end_q, cmd_top_q, cmd_sr_q;
  word_t      la_q, lc_q;
  logic       lf_q;
  logic       accept;
  word_t      sel_cnt;

  assign busy_o  = (state_q != ST_IDLE);
  assign accept  = start_i && !busy_o && !exit_i;
  assign sel_cnt = cnt_short_i ? widen_imm(cnt_imm_i) : cnt_reg_i;

  always_comb begin
    state_d     = state_q;
    push_o      = 1'b0;
    pop_o       = 1'b0;
    push_data_o = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (exit_i) begin
          pop_o   = 1'b1;
          state_d = ST_UNWIND;
        end else if (accept) begin
          state_d = ST_SAVE_CNT;
        end
      end
      ST_SAVE_CNT: begin
        push_o      = 1'b1;
        push_data_o = '{hi: la_q, lo: lc_q};
        state_d     = ST_SAVE_PC;
      end
      ST_SAVE_PC: begin
        push_o      = 1'b1;
        push_data_o = '{hi: cmd_top_q, lo: pack_status(cmd_sr_q, lf_q)};
        state_d     = ST_ARM;
      end
      ST_ARM:    state_d = ST_IDLE;
      ST_UNWIND: begin
        pop_o   = 1'b1;
        state_d = ST_IDLE;
      end
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cmd_cnt_q <= '0;
      cmd_end_q <= '0;
      cmd_top_q <= '0;
      cmd_sr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        cmd_cnt_q <= sel_cnt;
        cmd_end_q <= end_addr_i;
        cmd_top_q <= loop_top_i;
        cmd_sr_q  <= status_i;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      la_q <= '0;
      lc_q <= '0;
      lf_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (repeat_i)    lc_q <= lc_after_pass(lc_q);
          else if (exit_i) lf_q <= stk_top_i.lo[LF_POS];
        end
        ST_SAVE_CNT: lc_q <= cmd_cnt_q;
        ST_SAVE_PC:  la_q <= cmd_end_q;
        ST_ARM:      lf_q <= 1'b1;
        ST_UNWIND: begin
          la_q <= stk_top_i.hi;
          lc_q <= stk_top_i.lo;
        end
        default: ;
      endcase
    end
  end

  assign la_o = la_q;
  assign lc_o = lc_q;
  assign lf_o = lf_q;

  AST_SETUP_STEP1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SAVE_CNT) |=> (state_q == ST_SAVE_PC)); // R2
  AST_SETUP_STEP2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SAVE_PC) |=> (state_q == ST_ARM)); // R2
  AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && (state_q != ST_ARM) && (state_q != ST_UNWIND)) |=> busy_o); // R2
  AST_COUNT_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SAVE_CNT) |=> (lc_q == $past(cmd_cnt_q))); // R3
  AST_END_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SAVE_PC) |=> (la_q == $past(cmd_end_q))); // R4
  AST_ARM_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARM) |=> lf_q); // R5
  AST_PASS_DECREMENTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repeat_i |=> (lc_q == ($past(lc_q) - word_t'(1)))); // R6
  AST_UNWIND_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_UNWIND) |=> (state_q == ST_IDLE)); // R8

endmodule

// File: rtl/hwloop_ctrl.sv
`timescale 1ns/1ps
module hwloop_ctrl
  import hwloop_pkg::*;
#(
  parameter int unsigned STK_DEPTH = 15,
  localparam int unsigned DEPTH_W = $clog2(STK_DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               loop_start_i,
  input  logic               cnt_short_i,
  input  logic [IMM_W-1:0]   cnt_imm_i,
  input  logic [WORD_W-1:0]  cnt_reg_i,
  input  logic [WORD_W-1:0]  end_addr_i,
  input  logic [WORD_W-1:0]  loop_top_i,
  input  logic [WORD_W-1:0]  status_i,
  input  logic               fetch_vld_i,
  input  logic [WORD_W-1:0]  fetch_pc_i,
  output logic               busy_o,
  output logic               pc_ovr_vld_o,
  output logic [WORD_W-1:0]  pc_ovr_o,
  output logic [WORD_W-1:0]  lc_o,
  output logic [WORD_W-1:0]  la_o,
  output logic               lf_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               ovf_o,
  output logic               unf_o
);

  logic   push, pop, hit, pass_repeat, pass_exit;
  frame_t push_data, stk_top;
  word_t  la, lc;
  logic   lf, busy;

  hwloop_match u_match (
    .enable_i   (!busy),
    .lf_i       (lf),
    .fetch_vld_i(fetch_vld_i),
    .fetch_pc_i (fetch_pc_i),
    .la_i       (la),
    .lc_i       (lc),
    .hit_o      (hit),
    .repeat_o   (pass_repeat),
    .exit_o     (pass_exit)
  );

  hwloop_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (loop_start_i),
    .cnt_short_i(cnt_short_i),
    .cnt_imm_i  (cnt_imm_i),
    .cnt_reg_i  (cnt_reg_i),
    .end_addr_i (end_addr_i),
    .loop_top_i (loop_top_i),
    .status_i   (status_i),
    .repeat_i   (pass_repeat),
    .exit_i     (pass_exit),
    .stk_top_i  (stk_top),
    .push_o     (push),
    .pop_o      (pop),
    .push_data_o(push_data),
    .la_o       (la),
    .lc_o       (lc),
    .lf_o       (lf),
    .busy_o     (busy)
  );

  hwloop_stack #(.DEPTH(STK_DEPTH)) u_stack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop),
    .din_i  (push_data),
    .top_o  (stk_top),
    .depth_o(depth_o),
    .ovf_o  (ovf_o),
    .unf_o  (unf_o)
  );

  assign pc_ovr_vld_o = pass_repeat;
  assign pc_ovr_o     = stk_top.hi;
  assign busy_o       = busy;
  assign la_o         = la;
  assign lc_o         = lc;
  assign lf_o         = lf;

  AST_REDIRECT_NEEDS_LOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_ovr_vld_o |-> (lf_o && !busy_o && hit)); // R6
  AST_REDIRECT_KEEPS_DEPTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_ovr_vld_o |=> (depth_o == $past(depth_o))); // R6
  AST_EXIT_STARTS_UNWIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_exit |=> (busy_o && !pc_ovr_vld_o)); // R8

endmodule

// File: tb/test_hwloop_ctrl.sv
`timescale 1ns/1ps
module test_hwloop_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, short_sel, fvld;
  logic [18:0] imm;
  logic [31:0] creg, eaddr, ltop, sr, fpc;
  logic        busy, ovr_vld, lf, ovf, unf;
  logic [31:0] ovr, lc, la;
  logic [3:0]  depth;

  int checks = 0;
  int errors = 0;
  logic        got_vld;
  logic [31:0] got_pc;

  always #5 clk = ~clk;

  hwloop_ctrl i_hwloop_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .loop_start_i(start), .cnt_short_i(short_sel),
    .cnt_imm_i(imm), .cnt_reg_i(creg), .end_addr_i(eaddr), .loop_top_i(ltop),
    .status_i(sr), .fetch_vld_i(fvld), .fetch_pc_i(fpc), .busy_o(busy),
    .pc_ovr_vld_o(ovr_vld), .pc_ovr_o(ovr), .lc_o(lc), .la_o(la), .lf_o(lf),
    .depth_o(depth), .ovf_o(ovf), .unf_o(unf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 0; short_sel = 0; fvld = 0;
    imm = '0; creg = '0; eaddr = '0; ltop = '0; sr = '0; fpc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  // Returns one negedge after the flag is up (three busy cycles elapsed).
  task automatic start_loop(input logic sh, input logic [18:0] im, input logic [31:0] cnt,
                            input logic [31:0] e, input logic [31:0] t);
    @(negedge clk);
    start = 1; short_sel = sh; imm = im; creg = cnt; eaddr = e; ltop = t;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic fetch(input logic [31:0] pc);
    @(negedge clk);
    fvld = 1; fpc = pc;
    #1;
    got_vld = ovr_vld; got_pc = ovr;
    @(negedge clk);
    fvld = 0;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 lf", {31'b0, lf}, 0);
    chk("R1 lc", lc, 0);
    chk("R1 la", la, 0);
    chk("R1 depth", {28'b0, depth}, 0);
    chk("R1 busy/ovr/ovf/unf", {28'b0, busy, ovr_vld, ovf, unf}, 0);
  endtask

  task automatic t_single();
    do_reset();
    @(negedge clk);
    start = 1; creg = 32'd3; eaddr = 32'h100; ltop = 32'hF0;
    @(negedge clk); start = 0; #1;
    chk("R2 busy setup cycle 1", {31'b0, busy}, 1);
    @(negedge clk);
    start = 1; creg = 32'd9; eaddr = 32'h999; #1;   // ignored while busy
    chk("R2 busy setup cycle 2", {31'b0, busy}, 1);
    @(negedge clk); start = 0; #1;
    chk("R2 busy setup cycle 3", {31'b0, busy}, 1);
    @(negedge clk); #1;
    chk("R2 busy low after setup", {31'b0, busy}, 0);
    chk("R3 count loaded", lc, 3);
    chk("R4 end address loaded", la, 32'h100);
    chk("R4 depth after setup", {28'b0, depth}, 2);
    chk("R5 flag set", {31'b0, lf}, 1);
    @(negedge clk); #1;
    chk("R2 start in busy ignored", {28'b0, depth}, 2);
    fetch(32'hFC);
    chk("R6 other address no redirect", {31'b0, got_vld}, 0);
    chk("R6 other address keeps count", lc, 3);
    fetch(32'h100);
    chk("R6 redirect valid", {31'b0, got_vld}, 1);
    chk("R6 redirect target", got_pc, 32'hF0);
    chk("R6 count decremented", lc, 2);
    chk("R6 depth unchanged", {28'b0, depth}, 2);
    fetch(32'h100);
    chk("R6 second pass count", lc, 1);
    fetch(32'h100);
    chk("R8 last pass no redirect", {31'b0, got_vld}, 0);
    chk("R8 unwind busy", {31'b0, busy}, 1);
    chk("R8 flag restored", {31'b0, lf}, 0);
    chk("R8 depth after first pop", {28'b0, depth}, 1);
    @(negedge clk); #1;
    chk("R8 unwind done", {31'b0, busy}, 0);
    chk("R8 end address restored", la, 0);
    chk("R8 count restored", lc, 0);
    chk("R8 depth empty", {28'b0, depth}, 0);
  endtask

  task automatic t_short_count();
    do_reset();
    start_loop(1'b1, 19'h7FFFF, 32'hDEAD0000, 32'h40, 32'h20);
    chk("R3 short count zero-extended", lc, 32'h0007FFFF);
  endtask

  task automatic t_zero_count();
    do_reset();
    start_loop(1'b0, '0, 32'd0, 32'h80, 32'h60);
    chk("R7 zero count loaded", lc, 0);
    fetch(32'h80);
    chk("R7 zero count redirects", {31'b0, got_vld}, 1);
    chk("R7 zero count target", got_pc, 32'h60);
    chk("R7 count wraps", lc, 32'hFFFFFFFF);
    fetch(32'h80);
    chk("R7 next pass", lc, 32'hFFFFFFFE);
  endtask

  task automatic t_nested();
    do_reset();
    start_loop(1'b0, '0, 32'd2, 32'h200, 32'h180);
    start_loop(1'b0, '0, 32'd2, 32'h1C0, 32'h1A0);
    chk("R9 nested depth", {28'b0, depth}, 4);
    fetch(32'h1C0);
    chk("R9 inner redirect target", got_pc, 32'h1A0);
    fetch(32'h1C0);
    chk("R9 inner exit keeps flag", {31'b0, lf}, 1);
    @(negedge clk); #1;
    chk("R9 outer end restored", la, 32'h200);
    chk("R9 outer count restored", lc, 2);
    chk("R9 depth back", {28'b0, depth}, 2);
    fetch(32'h200);
    chk("R9 outer redirect valid", {31'b0, got_vld}, 1);
    chk("R9 outer redirect target", got_pc, 32'h180);
  endtask

  task automatic t_collide_repeat();
    do_reset();
    start_loop(1'b0, '0, 32'd5, 32'h300, 32'h2F0);
    @(negedge clk);
    start = 1; creg = 32'd1; eaddr = 32'h2F8; ltop = 32'h301;
    fvld = 1; fpc = 32'h300;
    #1;
    chk("R6 redirect with start", {31'b0, ovr_vld}, 1);
    chk("R6 redirect target with start", ovr, 32'h2F0);
    @(negedge clk); start = 0; fvld = 0; #1;
    chk("R2 start accepted with pass", {31'b0, busy}, 1);
    repeat (3) @(negedge clk);
    #1;
    chk("R2 inner end loaded", la, 32'h2F8);
    chk("R4 depth four", {28'b0, depth}, 4);
    fetch(32'h2F8);
    @(negedge clk); #1;
    chk("R8 saved count was decremented", lc, 4);
    chk("R8 outer end back", la, 32'h300);
    chk("R9 outer flag back", {31'b0, lf}, 1);
  endtask

  task automatic t_collide_exit();
    do_reset();
    start_loop(1'b0, '0, 32'd1, 32'h400, 32'h3F0);
    @(negedge clk);
    start = 1; creg = 32'd7; eaddr = 32'h500; ltop = 32'h480;
    fvld = 1; fpc = 32'h400;
    #1;
    chk("R8 exit no redirect", {31'b0, ovr_vld}, 0);
    @(negedge clk); start = 0; fvld = 0; #1;
    chk("R8 exit unwinds", {31'b0, lf}, 0);
    @(negedge clk); #1;
    chk("R2 start dropped on exit", {28'b0, depth}, 0);
    @(negedge clk); #1;
    chk("R2 no setup after exit", {31'b0, busy}, 0);
    chk("R2 depth stays empty", {28'b0, depth}, 0);
  endtask

  task automatic t_overflow();
    do_reset();
    sr = 32'h2;
    for (int k = 1; k <= 8; k++) begin
      start_loop(1'b0, '0, 32'd1, 32'h1000 + k * 16, 32'h1000 + k * 16 - 8);
      if (k == 7) begin
        chk("R10 depth 14 no overflow", {27'b0, depth, ovf}, {27'b0, 4'd14, 1'b0});
      end
    end
    chk("R10 depth saturates", {28'b0, depth}, 15);
    chk("R10 overflow set", {31'b0, ovf}, 1);
    for (int it = 0; it < 120; it++) begin
      if (unf) break;
      fetch(la);
    end
    chk("R11 underflow set", {31'b0, unf}, 1);
    chk("R11 depth stays zero", {28'b0, depth}, 0);
    @(negedge clk); #1;
    chk("R11 underflow sticky", {31'b0, unf}, 1);
    chk("R10 overflow sticky", {31'b0, ovf}, 1);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_short_count();
    t_zero_count();
    t_nested();
    t_collide_repeat();
    t_collide_exit();
    t_overflow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule